// File: doc/BRIEF.md
# Quadrature Spectrum Power Compressor

This block reduces one streamed quadrature spectrum to a short run of compact bytes. The spectrum arrives as 1024 frequency points, each made of a signed 16-bit in-phase word and a signed 16-bit quadrature word. For every point the block forms the power (sum of the two squares). It sums the powers over consecutive frequency bins whose widths grow with frequency, which keeps the bin width roughly proportional to frequency. It divides each bin sum by its width to get the mean, and takes the integer square root of the mean.

The root is scaled down by a programmable right shift and packed into an 8-bit floating-point code. The relative error of this code never exceeds 6.25%. A 4 KB frame becomes 220 bytes, so the compression ratio is about 18.6. The bytes leave on a valid/ready stream, and a last flag marks the final byte of a frame. Input acceptance stops while a bin is being divided, rooted or emitted. A sticky flag records frames whose end marker arrives in the wrong place.

Top module: `qsc_compressor`

## Requirements
- R1: Each accepted point contributes I*I + Q*Q, with I and Q taken as two's-complement 16-bit values. The sum needs 33 bits, and no term is lost or wrapped. For example, I = Q = -32768 gives 2^31.
- R2: A frame is split into 220 bins in rising frequency order. The bins come in bands of (width × count), in this order: 1×32, 2×32, 3×32, 4×32, 5×20, 6×20, 8×35, 12×17. This covers exactly 1024 points.
- R3: The bin mean is floor(bin power sum / bin width).
- R4: The block takes the floor integer square root of each 32-bit mean, giving a 16-bit result.
- R5: The root is shifted right by `cfg_shift` (0 to 15) before encoding.
- R6: The output byte encodes a 16-bit value v as follows. If v < 16, bits [7:4] = 0 and bits [3:0] = v, which is exact. Otherwise let p be the index of the highest set bit of v. Then bits [7:4] = p-3 (at most 12) and bits [3:0] = the four bits just below bit p, truncated.
- R7: A byte is offered with `out_valid` and is held stable until `out_ready` is sampled high. `out_last` is high only with the 220th byte of a frame.
- R8: `in_ready` is high only while the block is accumulating. It is low from the completion of a bin until that bin's byte has been taken, so `in_ready` and `out_valid` are never high together.
- R9: If `in_last` is accepted on any point other than point 1023, the block sets `err` and discards the partial frame. The next point then starts bin 0 of a new frame. A frame ending correctly leaves `err` unchanged.
- R10: After reset, `in_ready` = 1, `out_valid` = 0 and `err` = 0. Once `err` is set it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 4 | Right shift applied to each root |
| in_valid | input | 1 | Input point valid |
| in_ready | output | 1 | Block can accept a point |
| in_i | input | 16 | In-phase sample, two's complement |
| in_q | input | 16 | Quadrature sample, two's complement |
| in_last | input | 1 | Marks the final point of a frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the byte |
| out_data | output | 8 | Encoded 8-bit float |
| out_last | output | 1 | Final byte of a frame |
| err | output | 1 | Sticky frame-boundary error |

## Verification
Whole frames are driven through the block with four sample patterns. The first is a linear ramp on I alone, which tells apart the bin boundaries and the growing bin widths. The second is a pseudo-random signed pair, which exercises rounding in the divide and the root over the full range. The third is a constant most-negative pair, which reaches the largest power and the largest exponent. The fourth is a set of tiny values, which can only come out right through the exact small-value path of the encoder. A nonzero shift separates the scaling stage from the root. A stalling downstream checks that the output is held and that `in_ready` stays low. A one-point frame with an early end marker shows the error flag and the restart at bin 0.

// File: rtl/qsc_pkg.sv
package qsc_pkg;

  typedef enum logic [1:0] {ST_ACC, ST_DIV, ST_ROOT, ST_OUT} qsc_state_e;

  localparam int NUM_BANDS = 8;

  // width of every bin inside band b
  function automatic int band_width(int b);
    case (b)
      0: return 1;
      1: return 2;
      2: return 3;
      3: return 4;
      4: return 5;
      5: return 6;
      6: return 8;
      default: return 12;
    endcase
  endfunction

  // number of bins inside band b
  function automatic int band_bins(int b);
    case (b)
      0, 1, 2, 3: return 32;
      4, 5: return 20;
      6: return 35;
      default: return 17;
    endcase
  endfunction

  // 4-bit exponent, 4-bit truncated mantissa, hidden one above exponent 0
  function automatic logic [7:0] fp8_encode(logic [15:0] v);
    int p;
    logic [15:0] sh;
    if (v < 16'd16) return {4'd0, v[3:0]};
    p = 4;
    for (int k = 4; k < 16; k++)
      if (v[k]) p = k;
    sh = v >> (p - 4);
    return {4'(p - 3), sh[3:0]};
  endfunction

endpackage

// File: rtl/qsc_bin_width.sv
module qsc_bin_width #(
  parameter int BIN_W  = 8,
  parameter int WMAX_W = 4
) (
  input  logic [BIN_W-1:0]  bin_idx,
  output logic [WMAX_W-1:0] width
);
  import qsc_pkg::*;

  always_comb begin
    int lo;
    width = '0;
    lo = 0;
    for (int b = 0; b < NUM_BANDS; b++) begin
      if (int'(bin_idx) >= lo && int'(bin_idx) < lo + band_bins(b))
        width = WMAX_W'(band_width(b));
      lo = lo + band_bins(b);
    end
  end
endmodule

// File: rtl/qsc_seq_div.sv
module qsc_seq_div #(
  parameter int NW = 37,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [NW-1:0] quot
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] dsr;
  logic [DW-1:0] rem;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW:0]   trial;

  assign trial = {rem, quot[NW-1]};

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      dsr  <= '0;
      quot <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(NW);
      rem  <= '0;
      dsr  <= den;
      quot <= num;
    end else if (busy) begin
      if (trial >= {1'b0, dsr}) begin
        rem  <= DW'(trial - {1'b0, dsr});
        quot <= {quot[NW-2:0], 1'b1};
      end else begin
        rem  <= trial[DW-1:0];
        quot <= {quot[NW-2:0], 1'b0};
      end
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qsc_seq_sqrt.sv
module qsc_seq_sqrt #(
  parameter int XW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [XW-1:0]   x,
  output logic            done,
  output logic [XW/2-1:0] root
);
  localparam int RTW = XW / 2;
  localparam int RMW = RTW + 3;
  localparam int CW  = $clog2(RTW + 1);

  logic [XW-1:0]  xs;
  logic [RMW-1:0] rem;
  logic [CW-1:0]  cnt;
  logic           busy;
  logic [RMW-1:0] rem_sh;
  logic [RMW-1:0] trial;

  assign rem_sh = {rem[RMW-3:0], xs[XW-1:XW-2]};
  assign trial  = {{(RMW-RTW-2){1'b0}}, root, 2'b01};

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
      xs   <= '0;
      rem  <= '0;
      root <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(RTW);
      xs   <= x;
      rem  <= '0;
      root <= '0;
    end else if (busy) begin
      if (rem_sh >= trial) begin
        rem  <= rem_sh - trial;
        root <= {root[RTW-2:0], 1'b1};
      end else begin
        rem  <= rem_sh;
        root <= {root[RTW-2:0], 1'b0};
      end
      xs  <= xs << 2;
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/qsc_compressor.sv
module qsc_compressor #(
  parameter int SW     = 16,
  parameter int NPTS   = 1024,
  parameter int NBINS  = 220,
  parameter int WMAX_W = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    cfg_shift,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [SW-1:0] in_i,
  input  logic [SW-1:0] in_q,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic          err
);
  import qsc_pkg::*;

  localparam int PT_W  = $clog2(NPTS);
  localparam int BIN_W = $clog2(NBINS);
  localparam int PW    = 2 * SW + 1;
  localparam int ACC_W = PW + WMAX_W;
  localparam int MW    = 2 * SW;

  qsc_state_e          st;
  logic [PT_W-1:0]     pt_cnt;
  logic [BIN_W-1:0]    bin_idx;
  logic [WMAX_W-1:0]   fill;
  logic [ACC_W-1:0]    acc;
  logic [WMAX_W-1:0]   bin_w;
  logic signed [MW-1:0] sq_i, sq_q;
  logic [PW-1:0]       pwr;
  logic [ACC_W-1:0]    acc_nx;
  logic                fire, early, at_end, bin_full, div_go;
  logic                div_done, root_done;
  logic [ACC_W-1:0]    quot;
  logic [SW-1:0]       root;
  logic [SW-1:0]       scaled;

  assign in_ready = (st == ST_ACC);
  assign fire     = in_valid && in_ready;
  assign at_end   = (pt_cnt == PT_W'(NPTS - 1));
  assign early    = in_last && !at_end;
  assign bin_full = ((fill + 1'b1) == bin_w);
  assign div_go   = fire && !early && bin_full;

  assign sq_i   = $signed(in_i) * $signed(in_i);
  assign sq_q   = $signed(in_q) * $signed(in_q);
  assign pwr    = {1'b0, sq_i} + {1'b0, sq_q};
  assign acc_nx = acc + ACC_W'(pwr);
  assign scaled = root >> cfg_shift;

  qsc_bin_width #(.BIN_W(BIN_W), .WMAX_W(WMAX_W)) u_width (
    .bin_idx (bin_idx),
    .width   (bin_w)
  );

  qsc_seq_div #(.NW(ACC_W), .DW(WMAX_W)) u_div (
    .clk   (clk),
    .rst   (rst),
    .start (div_go),
    .num   (acc_nx),
    .den   (bin_w),
    .done  (div_done),
    .quot  (quot)
  );

  qsc_seq_sqrt #(.XW(MW)) u_sqrt (
    .clk   (clk),
    .rst   (rst),
    .start (div_done),
    .x     (quot[MW-1:0]),
    .done  (root_done),
    .root  (root)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_ACC;
      pt_cnt    <= '0;
      bin_idx   <= '0;
      fill      <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
      err       <= 1'b0;
    end else begin
      case (st)
        ST_ACC: if (fire) begin
          if (early) begin
            err     <= 1'b1;
            pt_cnt  <= '0;
            bin_idx <= '0;
            fill    <= '0;
            acc     <= '0;
          end else begin
            if (at_end && !in_last) err <= 1'b1;
            pt_cnt <= at_end ? '0 : pt_cnt + 1'b1;
            if (bin_full) begin
              acc  <= '0;
              fill <= '0;
              st   <= ST_DIV;
            end else begin
              acc  <= acc_nx;
              fill <= fill + 1'b1;
            end
          end
        end
        ST_DIV: if (div_done) st <= ST_ROOT;
        ST_ROOT: if (root_done) begin
          out_data  <= fp8_encode(scaled);
          out_valid <= 1'b1;
          out_last  <= (bin_idx == BIN_W'(NBINS - 1));
          st        <= ST_OUT;
        end
        default: if (out_ready) begin
          out_valid <= 1'b0;
          out_last  <= 1'b0;
          bin_idx   <= (bin_idx == BIN_W'(NBINS - 1)) ? '0 : bin_idx + 1'b1;
          st        <= ST_ACC;
        end
      endcase
    end
  end
endmodule

// File: rtl/qsc_compressor_chk.sv
module qsc_compressor_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       err
);
  // R8
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R7
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R6
  exp_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data[7:4] <= 4'd12);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind qsc_compressor qsc_compressor_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .err       (err)
);

// File: tb/sim_qsc_compressor.sv
module sim_qsc_compressor;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 1024;
  localparam int NB = 220;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_shift = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_i = '0;
  logic [15:0] in_q = '0;
  logic        in_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        out_last;
  logic        err;

  int total = 0;
  int bad = 0;
  int expb [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  qsc_compressor u0 (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift),
    .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
    .in_last(in_last), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .err(err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exv);
    end
  endtask

  // R2 band table
  function automatic int ref_width(int b);
    int w[8] = '{1, 2, 3, 4, 5, 6, 8, 12};
    int n[8] = '{32, 32, 32, 32, 20, 20, 35, 17};
    int lo = 0;
    for (int k = 0; k < 8; k++) begin
      if (b < lo + n[k]) return w[k];
      lo += n[k];
    end
    return 0;
  endfunction

  function automatic longint ref_isqrt(longint x);
    longint r = 0;
    for (int bit_i = 15; bit_i >= 0; bit_i--) begin
      longint c = r | (64'd1 << bit_i);
      if (c * c <= x) r = c;
    end
    return r;
  endfunction

  function automatic int ref_enc(longint v);
    int e = 1;
    if (v < 16) return int'(v);
    while ((v >> (e - 1)) >= 32) e++;
    return e * 16 + int'((v >> (e - 1)) - 16);
  endfunction

  function automatic void sample(int kind, int idx, output longint si, output longint sq);
    case (kind)
      0: begin si = idx * 31; sq = 0; end
      1: begin si = ((idx * 40503 + 12345) % 65536) - 32768;
               sq = ((idx * 9973 + 777) % 65536) - 32768; end
      2: begin si = -32768; sq = -32768; end
      default: begin si = (idx % 7) - 3; sq = (idx % 5) - 2; end
    endcase
  endfunction

  task automatic build_expect(int kind, int shift);
    int pt = 0;
    for (int b = 0; b < NB; b++) begin
      longint sum = 0;
      int w = ref_width(b);
      for (int k = 0; k < w; k++) begin
        longint si, sq;
        sample(kind, pt, si, sq);
        sum += si * si + sq * sq;
        pt++;
      end
      expb[b] = ref_enc(ref_isqrt(sum / w) >> shift);
    end
  endtask

  task automatic send(longint si, longint sq, bit last);
    in_valid = 1'b1;
    in_i = 16'(si);
    in_q = 16'(sq);
    in_last = last;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drive_frame(int kind);
    for (int idx = 0; idx < NP; idx++) begin
      longint si, sq;
      sample(kind, idx, si, sq);
      send(si, sq, idx == NP - 1);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic collect(bit stall, string req);
    int n = 0;
    int tick = 0;
    while (n < NB) begin
      @(negedge clk);
      tick++;
      out_ready = !stall || (tick % 3 != 0);
      if (out_valid && out_ready) begin
        check(out_data == 8'(expb[n]), req, out_data, expb[n]);
        // R7 last flag on final byte only
        check(out_last == (n == NB - 1), "R7", out_last, n == NB - 1);
        // R8 no input acceptance while a byte is offered
        check(in_ready == 1'b0, "R8", in_ready, 0);
        n++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_frame(int kind, int shift, bit stall, string req);
    build_expect(kind, shift);
    cfg_shift = 4'(shift);
    fork
      drive_frame(kind);
      collect(stall, req);
    join
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check(in_ready == 1'b1, "R10 in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
    check(err == 1'b0, "R10 err", err, 0);

    run_frame(0, 0, 1'b0, "R1/R2/R3/R4/R6 ramp");
    run_frame(1, 0, 1'b1, "R1/R3/R4/R6/R7 random stalled");
    run_frame(2, 0, 1'b0, "R1/R4/R6 max power");
    run_frame(3, 0, 1'b0, "R6 small exact");
    run_frame(1, 4, 1'b0, "R5 shift 4");
    // R9 well-formed frames leave err clear
    check(err == 1'b0, "R9 no false error", err, 0);

    // R9 early end marker on point 0
    send(5, 7, 1'b1);
    in_valid = 1'b0;
    in_last = 1'b0;
    seen = 1'b0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    check(seen == 1'b0, "R9 discarded frame emits nothing", seen, 0);
    check(err == 1'b1, "R9 err set", err, 1);

    run_frame(3, 0, 1'b0, "R9 restart at bin 0");
    // R10 sticky
    check(err == 1'b1, "R10 err sticky", err, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule